// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

One timer channel that turns a 16-bit up-counter into a pulse-width-modulated pin. A prescaler divides the system clock by a power of four, and each divided tick advances the counter. The counter runs from zero up to a programmed period value and then wraps. The pin is in its inactive phase at the start of each period. It enters the active phase once the count reaches a programmed duty value. A polarity bit chooses whether the active phase drives the pin high or low.

The counter enable and the pin enable are separate. Software programs the period, duty, divider and polarity. It may preset the counter through a load port, and it then raises the two enables. To stop the channel, software clears the pin enable first. If abrupt shutdown is selected, the pin returns to its initial level at once. If it is not selected, the pin keeps its present level until the running period ends. After that, the counter enable may be dropped.

A small state machine decides the pin level. `ST_OFF` drives the initial level. `ST_RUN` drives the level from the duty comparison. `ST_DRAIN` holds the last level until the period ends. The transitions are: OFF to RUN when the pin enable rises. RUN to OFF when the pin enable drops with abrupt shutdown selected. RUN to DRAIN when it drops without abrupt shutdown. DRAIN to RUN when the pin enable returns. DRAIN to OFF at the period wrap, or when abrupt shutdown is selected.

Top module: `pwm_timer_chan`

## Requirements
- R1: The prescaler select `div_sel` (0 to 5) sets the tick interval to 4 to the power `div_sel` clock cycles: 1, 4, 16, 64, 256 or 1024.
- R2: With no load, one period lasts `period_val`+1 ticks. In the clock cycle that follows each wrap from `period_val` to zero, `match_pulse` is high for exactly one cycle.
- R3: While running, the active phase is driven when the count is at least `duty_val`, so every period with a non-zero duty begins inactive.
- R4: When `duty_val` is greater than `period_val`, the pin never enters the active phase.
- R5: With `act_low`=1 the pin is low in the active phase and high otherwise. With `act_low`=0 it is the other way round.
- R6: When `load_en` is high, the counter takes `load_val` at the next edge. The load wins over a tick, and no `match_pulse` follows that edge. Loading zero restarts the period.
- R7: With `abrupt_off`=1, clearing `pwm_en` returns the pin to the inactive level for the current polarity at the next clock edge.
- R8: With `abrupt_off`=0, clearing `pwm_en` holds the present pin level until the period wraps. The pin shows the inactive level in the cycle that carries `match_pulse`.
- R9: During reset the counter, divider and state are cleared, `match_pulse` is low, and the pin equals `act_low`.
- R10: The divider count is zero whenever `cnt_en` is low. The first tick after `cnt_en` rises therefore comes one full interval later; with `div_sel`=1, that is the fourth enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter (and prescaler) enable |
| pwm_en | input | 1 | Pin output enable |
| div_sel | input | 3 | Prescaler select, divide by 4^div_sel (values above 5 act as 5) |
| act_low | input | 1 | Active phase drives the pin low |
| abrupt_off | input | 1 | Stop the pin at once when pwm_en clears |
| period_val | input | 16 | Terminal count of a period |
| duty_val | input | 16 | Count at which the active phase starts |
| load_en | input | 1 | Load the counter with load_val |
| load_val | input | 16 | Counter preset value |
| pwm_out | output | 1 | PWM pin level |
| match_pulse | output | 1 | One-cycle pulse after each period wrap |

## Verification
Two functions can coincide in one cycle. A counter load can fall on the tick where the count equals the period, and a non-abrupt shutdown ends on the same edge as the period wrap. The bench provokes the first case by asserting the load exactly when the count reaches the period. It then expects no `match_pulse` after that edge, and a fresh full period before the next pulse. For the second case, the bench clears the pin enable during the active phase. It expects the pin to stay active up to the wrap and to read inactive in the very cycle that carries `match_pulse`.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } out_state_e;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int SEL_W   = 3,
    parameter int SEL_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = 2 * SEL_MAX;

    logic [SEL_W-1:0] sel_c;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] pre_q;

    always_comb begin
        sel_c = (sel > SEL_W'(SEL_MAX)) ? SEL_W'(SEL_MAX) : sel;
        limit = DIV_W'((32'd1 << (2 * sel_c)) - 32'd1);
        tick  = run && (pre_q == limit);
    end

    // Divider count is held at zero while stopped: a fresh enable waits a full interval.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/pwm_count.sv
module pwm_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             match
);
    logic [CNT_W-1:0] cnt_q;
    logic             match_q;

    assign wrap  = tick && !load && (cnt_q == period);
    assign cnt   = cnt_q;
    assign match = match_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            match_q <= wrap;
            if (load) begin
                cnt_q <= load_val;
            end else if (wrap) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/pwm_outfsm.sv
module pwm_outfsm
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_en,
    input  logic             abrupt,
    input  logic             act_low,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] period,
    input  logic             wrap,
    output logic             pin
);
    out_state_e state_q, state_d;
    logic       hold_q;
    logic       cmp_act;
    logic       lvl;

    assign cmp_act = (duty <= period) && (cnt >= duty);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (out_en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!out_en) state_d = abrupt ? ST_OFF : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (out_en)               state_d = ST_RUN;
                else if (abrupt || wrap)  state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Level frozen when the run phase is left without abrupt shutdown.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (state_q == ST_RUN && !out_en) begin
            hold_q <= cmp_act;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   lvl = cmp_act;
            ST_DRAIN: lvl = hold_q;
            default:  lvl = 1'b0;
        endcase
        pin = lvl ^ act_low;
    end
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan #(
    parameter int CNT_W   = 16,
    parameter int SEL_W   = 3,
    parameter int SEL_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             pwm_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             act_low,
    input  logic             abrupt_off,
    input  logic [CNT_W-1:0] period_val,
    input  logic [CNT_W-1:0] duty_val,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic             pwm_out,
    output logic             match_pulse
);
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    pwm_prescale #(.SEL_W(SEL_W), .SEL_MAX(SEL_MAX)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (cnt_en),
        .sel  (div_sel),
        .tick (tick)
    );

    pwm_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (load_en),
        .load_val(load_val),
        .period  (period_val),
        .cnt     (cnt),
        .wrap    (wrap),
        .match   (match_pulse)
    );

    pwm_outfsm #(.CNT_W(CNT_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .out_en (pwm_en),
        .abrupt (abrupt_off),
        .act_low(act_low),
        .cnt    (cnt),
        .duty   (duty_val),
        .period (period_val),
        .wrap   (wrap),
        .pin    (pwm_out)
    );
endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             pwm_en,
    input logic             act_low,
    input logic             abrupt_off,
    input logic [CNT_W-1:0] period_val,
    input logic [CNT_W-1:0] duty_val,
    input logic             load_en,
    input logic             pwm_out,
    input logic             match_pulse
);
    // R7
    abrupt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en && abrupt_off && $past(!pwm_en && abrupt_off)) |-> (pwm_out == act_low));

    // R2
    match_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(cnt_en));

    // R6
    load_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_en) |-> !match_pulse);

    // R4
    duty_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && $past(pwm_en) && (duty_val > period_val)) |-> (pwm_out == act_low));

    // R9
    reset_level_chk: assert property (@(posedge clk)
        !rst_n |-> (!match_pulse && pwm_out == act_low));
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .pwm_en     (pwm_en),
    .act_low    (act_low),
    .abrupt_off (abrupt_off),
    .period_val (period_val),
    .duty_val   (duty_val),
    .load_en    (load_en),
    .pwm_out    (pwm_out),
    .match_pulse(match_pulse)
);

// File: tb/pwm_timer_chan_bench.sv
`timescale 1ns/1ps
module pwm_timer_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, pwm_en = 1'b0, act_low = 1'b0, abrupt_off = 1'b1;
    logic [2:0]  div_sel = 3'd0;
    logic [15:0] period_val = 16'd0, duty_val = 16'd0, load_val = 16'd0;
    logic        load_en = 1'b0;
    logic        pwm_out, match_pulse;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_timer_chan u_pwm_timer_chan (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pwm_en(pwm_en),
        .div_sel(div_sel), .act_low(act_low), .abrupt_off(abrupt_off),
        .period_val(period_val), .duty_val(duty_val), .load_en(load_en),
        .load_val(load_val), .pwm_out(pwm_out), .match_pulse(match_pulse)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] per;
        logic [15:0] dut;
        logic        pol;
        logic [15:0] act;
        logic [15:0] len;
    } vec_t;

    // active = (per-dut+1)*4^sel when dut<=per else 0; len = (per+1)*4^sel
    localparam vec_t VEC [6] = '{
        '{3'd0, 16'd9, 16'd3, 1'b0, 16'd7,    16'd10},
        '{3'd1, 16'd4, 16'd2, 1'b0, 16'd12,   16'd20},
        '{3'd0, 16'd5, 16'd7, 1'b0, 16'd0,    16'd6},
        '{3'd0, 16'd7, 16'd0, 1'b1, 16'd8,    16'd8},
        '{3'd2, 16'd3, 16'd1, 1'b1, 16'd48,   16'd64},
        '{3'd5, 16'd1, 16'd1, 1'b0, 16'd1024, 16'd2048}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_match(input int maxc);
        int n = 0;
        while (!match_pulse && n < maxc) begin
            @(negedge clk);
            n++;
        end
        check(match_pulse, "R2 match seen", int'(match_pulse), 1);
    endtask

    task automatic setup(input logic [2:0] s, input logic [15:0] p, input logic [15:0] d,
                         input logic pol, input logic abr);
        @(negedge clk);
        pwm_en = 1'b0; abrupt_off = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
        div_sel = s; period_val = p; duty_val = d; act_low = pol; abrupt_off = abr;
        load_val = 16'd0; load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0; cnt_en = 1'b1; pwm_en = 1'b1;
    endtask

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        act_low = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b1, "R9 pin at reset, act_low=1", int'(pwm_out), 1);
        check(match_pulse == 1'b0, "R9 match at reset", int'(match_pulse), 0);
        act_low = 1'b0;
        #1;
        check(pwm_out == 1'b0, "R9 pin at reset, act_low=0", int'(pwm_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table: R1 R2 R3 R4 R5
        foreach (VEC[i]) begin
            int active;
            bit early;
            setup(VEC[i].sel, VEC[i].per, VEC[i].dut, VEC[i].pol, 1'b1);
            wait_match(4 * int'(VEC[i].len));
            active = 0;
            early = 1'b0;
            if (VEC[i].dut != 16'd0)
                check(pwm_out == VEC[i].pol, "R3 period starts inactive", int'(pwm_out), int'(VEC[i].pol));
            for (int k = 0; k < int'(VEC[i].len); k++) begin
                if (pwm_out == !VEC[i].pol) active++;
                if (k != 0 && match_pulse) early = 1'b1;
                @(negedge clk);
            end
            check(active == int'(VEC[i].act), "R3 R4 R5 active cycles", active, int'(VEC[i].act));
            check(match_pulse && !early, "R1 R2 period length", int'(early), 0);
        end

        // R6: load zero mid period restarts
        setup(3'd0, 16'd9, 16'd3, 1'b0, 1'b1);
        wait_match(40);
        repeat (5) @(negedge clk);
        load_en = 1'b1; load_val = 16'd0;
        @(negedge clk);
        load_en = 1'b0;
        check(pwm_out == 1'b0, "R6 count zero after load", int'(pwm_out), 0);
        begin
            bit early = 1'b0;
            for (int k = 0; k < 9; k++) begin
                @(negedge clk);
                if (match_pulse) early = 1'b1;
            end
            check(!early, "R6 no early match after load", int'(early), 0);
            @(negedge clk);
            check(match_pulse, "R6 match after restarted period", int'(match_pulse), 1);
        end

        // R6: load falling on the terminal tick suppresses the wrap
        repeat (9) @(negedge clk);
        load_en = 1'b1; load_val = 16'd0;
        @(negedge clk);
        load_en = 1'b0;
        check(!match_pulse, "R6 load on wrap tick gives no match", int'(match_pulse), 0);
        repeat (9) @(negedge clk);
        check(!match_pulse, "R6 match not before full period", int'(match_pulse), 0);
        @(negedge clk);
        check(match_pulse, "R6 match after full period", int'(match_pulse), 1);

        // R10: first tick a full interval after enable
        @(negedge clk);
        pwm_en = 1'b0; abrupt_off = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0; div_sel = 3'd1; period_val = 16'd9; duty_val = 16'd1; act_low = 1'b0;
        load_en = 1'b1; load_val = 16'd0;
        @(negedge clk);
        load_en = 1'b0; pwm_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R10 no tick before interval", int'(pwm_out), 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R10 tick on fourth enabled cycle", int'(pwm_out), 1);
        @(negedge clk);
        cnt_en = 1'b0;
        @(negedge clk);
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0; cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R10 re-enable waits full interval", int'(pwm_out), 0);
        @(negedge clk);
        check(pwm_out == 1'b1, "R10 re-enable tick", int'(pwm_out), 1);

        // R7: abrupt shutdown, inverted pin
        setup(3'd0, 16'd9, 16'd3, 1'b1, 1'b1);
        wait_match(40);
        repeat (5) @(negedge clk);
        check(pwm_out == 1'b0, "R5 active phase low", int'(pwm_out), 0);
        pwm_en = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b1, "R7 abrupt return to initial level", int'(pwm_out), 1);

        // R8: graceful shutdown holds level to the wrap
        setup(3'd0, 16'd9, 16'd3, 1'b0, 1'b0);
        wait_match(40);
        repeat (5) @(negedge clk);
        pwm_en = 1'b0;
        begin
            int high = 0;
            int n = 0;
            @(negedge clk);
            while (!match_pulse && n < 40) begin
                if (pwm_out) high++;
                n++;
                @(negedge clk);
            end
            check(high == 4 && n == 4, "R8 level held until wrap", high, 4);
            check(pwm_out == 1'b0, "R8 inactive at wrap", int'(pwm_out), 0);
        end
        @(negedge clk);
        cnt_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule